// File: doc/BRIEF.md
# Serial Host Configuration Receiver

This block takes configuration commands from a host processor over three slow wires: a shift clock, a data line and a latch strobe. Each rising edge of the host clock shifts one bit into a 12-bit frame. The first eight bits are a data byte and the last four are a register address, each sent least significant bit first. When the latch wire falls, the block decodes the frame and updates the register it addresses.

The block holds two registers. The first is a mute colour made of three 4-bit components. The second is a 16-bit mask that enables graphics channels. The drawing-instruction decoder downstream reads the colour components directly. It also asks whether a channel is enabled by driving a channel index and reading a single enable bit, so that font-write and XOR-font commands run only on enabled channels. All three host pins are asynchronous to the system clock. Each one passes through a two-flop synchroniser before its edges are detected.

Top module: `hostcfg_serial_rx`

## Requirements
- R1: A frame is the last 12 bits shifted on rising edges of the host clock. Bits 0 to 7 are data bits D0..D7 and bits 8 to 11 are address bits A0..A3, so the first bit received is D0 and the last is A3.
- R2: Registers change only on a falling edge of the latch input. They do not change while bits are being shifted, and they do not change on a rising edge of the latch.
- R3: Address 0xC writes the mute colour. D7:D6 choose the component (00 red, 01 green, 10 blue) and D5:D2 give its 4-bit value, with D5 as the most significant bit. D1:D0 are ignored.
- R4: A colour command with D7:D6 = 11 changes no register.
- R5: Address 0xD writes one channel enable. D7 is the new value and D3:D0 give the channel number. D6:D4 are ignored, and no other channel changes.
- R6: After reset, red = 0000, green = 0000, blue = 1111 and the channel mask = 0x0003, so only channels 0 and 1 are enabled.
- R7: A frame whose address is not 0xC or 0xD changes no register.
- R8: `qry_en_o` equals the mask bit of the channel selected by `qry_chan_i`.
- R9: If more than 12 bits are shifted before the latch falls, only the last 12 bits count.
- R10: Host pins are synchronised with two flops. A register update shows at the outputs after the third rising edge of the system clock that follows the latch pin falling, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hclk_i | input | 1 | Host shift clock, asynchronous |
| hdat_i | input | 1 | Host serial data, asynchronous |
| hlat_i | input | 1 | Host latch strobe; idle high, falling edge applies the frame |
| mute_red_o | output | 4 | Red component of the mute colour |
| mute_grn_o | output | 4 | Green component of the mute colour |
| mute_blu_o | output | 4 | Blue component of the mute colour |
| chan_mask_o | output | 16 | Graphics channel enable mask |
| qry_chan_i | input | 4 | Channel index queried by the instruction decoder |
| qry_en_o | output | 1 | Enable bit of the queried channel |

## Verification
A wrong shift position or a reversed bit order sends a value to the wrong field or the wrong channel. This shows at the colour or mask outputs three system cycles after the latch falls. A broken edge detector either applies a frame early, which shows while bits are still being shifted, or misses the command, which leaves the outputs stale after the latch. Reset values are visible on the first sample after reset is released. The query output is compared against the mask for every channel index after selected commands.

// File: rtl/hostcfg_serial_rx.sv
module hostcfg_serial_rx #(
  parameter int CHANNELS    = 16,
  parameter int COMP_W      = 4,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_COLOUR = 4'hC,
  parameter logic [3:0] ADDR_CHAN   = 4'hD
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hclk_i,
  input  logic                        hdat_i,
  input  logic                        hlat_i,
  output logic [COMP_W-1:0]           mute_red_o,
  output logic [COMP_W-1:0]           mute_grn_o,
  output logic [COMP_W-1:0]           mute_blu_o,
  output logic [CHANNELS-1:0]         chan_mask_o,
  input  logic [$clog2(CHANNELS)-1:0] qry_chan_i,
  output logic                        qry_en_o
);
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int CH_W    = $clog2(CHANNELS);
  localparam int COL_LSB = DATA_W - 2 - COMP_W;
  localparam logic [CHANNELS-1:0] MASK_RST = CHANNELS'(3);

  logic [SYNC_STAGES-1:0] clk_sy, dat_sy, lat_sy;
  logic                   clk_q, lat_q;
  logic [FRAME_W-1:0]     frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sy <= '0;
      dat_sy <= '0;
      lat_sy <= '1;
      clk_q  <= 1'b0;
      lat_q  <= 1'b1;
    end else begin
      clk_sy <= {clk_sy[SYNC_STAGES-2:0], hclk_i};
      dat_sy <= {dat_sy[SYNC_STAGES-2:0], hdat_i};
      lat_sy <= {lat_sy[SYNC_STAGES-2:0], hlat_i};
      clk_q  <= clk_sy[SYNC_STAGES-1];
      lat_q  <= lat_sy[SYNC_STAGES-1];
    end
  end

  wire shift_stb = clk_sy[SYNC_STAGES-1] & ~clk_q;
  wire apply_stb = ~lat_sy[SYNC_STAGES-1] & lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         frame <= '0;
    else if (shift_stb) frame <= {dat_sy[SYNC_STAGES-1], frame[FRAME_W-1:1]};
  end

  wire [DATA_W-1:0] fdata  = frame[DATA_W-1:0];
  wire [ADDR_W-1:0] faddr  = frame[FRAME_W-1:DATA_W];
  wire [1:0]        sel    = fdata[DATA_W-1:DATA_W-2];
  wire [COMP_W-1:0] colval = fdata[COL_LSB +: COMP_W];
  wire [CH_W-1:0]   chnum  = fdata[CH_W-1:0];
  wire              chon   = fdata[DATA_W-1];
  wire              wr_col = apply_stb && (faddr == ADDR_W'(ADDR_COLOUR));
  wire              wr_ch  = apply_stb && (faddr == ADDR_W'(ADDR_CHAN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_red_o <= '0;
      mute_grn_o <= '0;
      mute_blu_o <= '1;
    end else if (wr_col) begin
      case (sel)
        2'b00:   mute_red_o <= colval;
        2'b01:   mute_grn_o <= colval;
        2'b10:   mute_blu_o <= colval;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     chan_mask_o <= MASK_RST;
    else if (wr_ch) chan_mask_o[chnum] <= chon;
  end

  assign qry_en_o = chan_mask_o[qry_chan_i];
endmodule

module hostcfg_serial_rx_chk #(
  parameter int CHANNELS = 16,
  parameter int COMP_W   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                apply_stb,
  input logic [COMP_W-1:0]   mute_red_o,
  input logic [COMP_W-1:0]   mute_grn_o,
  input logic [COMP_W-1:0]   mute_blu_o,
  input logic [CHANNELS-1:0] chan_mask_o
);
  assert_reset_values_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mute_red_o == '0 && mute_grn_o == '0 &&
                      mute_blu_o == '1 && chan_mask_o == CHANNELS'(3)));

  assert_hold_without_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_stb |=> ($stable(mute_red_o) && $stable(mute_grn_o) &&
                    $stable(mute_blu_o) && $stable(chan_mask_o)));

  assert_one_channel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chan_mask_o ^ $past(chan_mask_o)) <= 1);

  assert_one_component_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({mute_red_o != $past(mute_red_o), mute_grn_o != $past(mute_grn_o),
                 mute_blu_o != $past(mute_blu_o)}) <= 1));

  assert_regs_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(chan_mask_o)) |-> ($stable(mute_red_o) && $stable(mute_grn_o) &&
                                 $stable(mute_blu_o)));
endmodule

bind hostcfg_serial_rx hostcfg_serial_rx_chk #(.CHANNELS(CHANNELS), .COMP_W(COMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .apply_stb(apply_stb),
  .mute_red_o(mute_red_o), .mute_grn_o(mute_grn_o), .mute_blu_o(mute_blu_o),
  .chan_mask_o(chan_mask_o)
);

// File: tb/hostcfg_serial_rx_bench.sv
module hostcfg_serial_rx_bench;
  logic clk = 0, rst_n = 0, hclk = 0, hdat = 0, hlat = 1;
  logic [3:0] red, grn, blu, qch = 0;
  logic [15:0] mask;
  logic qen;
  int checks = 0, failures = 0;
  logic [3:0] m_red, m_grn, m_blu;
  logic [15:0] m_mask;
  bit done = 0;

  always #2 clk = ~clk;

  hostcfg_serial_rx u_hostcfg_serial_rx (
    .clk(clk), .rst_n(rst_n), .hclk_i(hclk), .hdat_i(hdat), .hlat_i(hlat),
    .mute_red_o(red), .mute_grn_o(grn), .mute_blu_o(blu),
    .chan_mask_o(mask), .qry_chan_i(qch), .qry_en_o(qen));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(string req);
    chk(req, {red, grn, blu, mask}, {m_red, m_grn, m_blu, m_mask});
  endtask

  function automatic void model(logic [11:0] f);
    logic [7:0] d = f[7:0];
    if (f[11:8] == 4'hC) begin
      case (d[7:6])
        2'b00: m_red = d[5:2];
        2'b01: m_grn = d[5:2];
        2'b10: m_blu = d[5:2];
        default: ;
      endcase
    end else if (f[11:8] == 4'hD) m_mask[d[3:0]] = d[7];
  endfunction

  task automatic bit_out(logic b);
    @(negedge clk) hdat = b;
    repeat (8) @(negedge clk);
    hclk = 1;
    repeat (8) @(negedge clk);
    hclk = 0;
  endtask

  task automatic send(logic [11:0] f, string req);
    for (int i = 0; i < 12; i++) bit_out(f[i]);
    repeat (8) @(negedge clk);
    chk({req, " R2 before latch"}, {red, grn, blu, mask}, {m_red, m_grn, m_blu, m_mask});
    hlat = 0;
    @(posedge clk); @(negedge clk);
    chk({req, " R10 not after one edge"}, {red, grn, blu, mask}, {m_red, m_grn, m_blu, m_mask});
    model(f);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk_regs({req, " R10 after three edges"});
    repeat (4) @(negedge clk);
    hlat = 1;
    repeat (8) @(negedge clk);
    chk_regs({req, " R2 latch rise"});
  endtask

  task automatic query_all(string req);
    for (int c = 0; c < 16; c++) begin
      qch = 4'(c);
      #1;
      chk(req, {31'd0, qen}, {31'd0, m_mask[c]});
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1807));
    m_red = 0; m_grn = 0; m_blu = 4'hF; m_mask = 16'h0003;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_regs("R6 reset values");
    query_all("R8 query after reset");
    send({4'hC, 2'b00, 4'hA, 2'b11}, "R3 red");
    chk("R3 red value", red, 4'hA);
    send({4'hC, 2'b01, 4'h5, 2'b00}, "R3 green");
    send({4'hC, 2'b10, 4'h3, 2'b10}, "R3 blue");
    chk("R3 blue value", blu, 4'h3);
    send({4'hC, 2'b11, 4'hF, 2'b11}, "R4 select 11");
    send({4'hD, 1'b1, 3'b111, 4'd15}, "R5 channel 15 on");
    chk("R5 ch15", mask, 16'h8003);
    send({4'hD, 1'b0, 3'b000, 4'd0}, "R5 channel 0 off");
    query_all("R8 query after edits");
    send({4'h6, 8'hFF}, "R7 reserved 6");
    send({4'hE, 8'h8F}, "R7 reserved E");
    for (int i = 0; i < 7; i++) bit_out(1'b1);
    send({4'hD, 1'b1, 3'b000, 4'd7}, "R9 extra leading bits");
    chk("R1 R9 ch7", mask[7], 1'b1);
    for (int n = 0; n < 40; n++) begin
      logic [11:0] f;
      int k = $urandom_range(0, 4);
      f[7:0] = 8'($urandom);
      f[11:8] = (k < 2) ? 4'hC : (k < 4) ? 4'hD : 4'($urandom);
      send(f, "R1 random frame");
    end
    query_all("R8 query after random");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule